// File: doc/BRIEF.md
# Polled Console Character Port

A one-character console interface on a simple request/acknowledge register bus. Four byte-wide registers are exposed: an input data buffer, an input status byte, an output data buffer and an output status byte. Software learns that a character is waiting by reading the input status. That read is also the moment the block samples its byte-stream source. If the source offers a byte, the byte is taken into the input buffer and the status becomes 1. If it offers none, both the buffer and the status are cleared. Software then reads the input data register to fetch the character.

Writing the output data register emits the byte at once on a byte-stream output, marked by a one-cycle valid strobe. The byte is kept as the last output byte, and the output status is set to 1 ("not full"). Software may overwrite either status byte and the input buffer directly. The block holds at most one character in each direction and applies no line encoding.

The bus front end is a small state machine with three states. ST_IDLE accepts a request. ST_READ_RESP returns read data with the acknowledge. ST_WRITE_RESP acknowledges a write. It has four transitions: ST_IDLE to ST_READ_RESP on a read request, ST_IDLE to ST_WRITE_RESP on a write request, and each response state back to ST_IDLE after one cycle. Register offsets are: 0 input data, 1 input status, 2 output data, 3 output status.

Top module: `cpc_console_port`

## Requirements
- R1: After reset, the output status reads 1, the input status is 0, and the input and output data buffers read 0.
- R2: A read of the input status (offset 1) while `src_valid` is high loads `src_data` into the input buffer, sets the input status to 1 and returns 1.
- R3: A read of the input status while `src_valid` is low clears both the input buffer and the input status to 0 and returns 0.
- R4: A read of the input data register (offset 0) returns the buffered character, leaves the input status unchanged and takes nothing from the source.
- R5: `src_ready` is high only in the cycle in which an input-status read is accepted, so exactly one byte is taken per such read and none otherwise.
- R6: A write to the output data register (offset 2) drives `snk_valid` high for exactly one cycle, with `snk_data` equal to the written byte in the acknowledge cycle, and sets the output status to 1.
- R7: A read of the output data register returns the last byte written to it.
- R8: Software writes to the input data (offset 0), input status (offset 1) and output status (offset 3) registers replace their current values with the written byte.
- R9: An accepted request is acknowledged for exactly one cycle, in the cycle after it. Read data is valid with the acknowledge. A request presented during the acknowledge cycle is ignored.
- R10: Writes to any register other than the output data register produce no `snk_valid` pulse and take nothing from the source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Register access request, accepted in ST_IDLE |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | DATA_W | Write data |
| bus_ack | output | 1 | One-cycle acknowledge |
| bus_rdata | output | DATA_W | Read data, valid with bus_ack |
| src_valid | input | 1 | Source offers a byte |
| src_data | input | DATA_W | Source byte |
| src_ready | output | 1 | Byte taken this cycle |
| snk_valid | output | 1 | Output byte strobe |
| snk_data | output | DATA_W | Last output byte |

## Verification
A wrong capture decision is visible on the very next acknowledge. The status read returns the post-sample value, and the following input-data read returns the buffered byte, so a missed or stale capture shows up within two bus transactions. A handshake that fires at the wrong time is seen at once as an extra or missing source acceptance, counted against the status reads issued. A state machine stuck outside ST_IDLE or a doubled strobe shows up in the cycle after the acknowledge, as a repeated `bus_ack` or `snk_valid`.

// File: rtl/cpc_pkg.sv
package cpc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_READ_RESP  = 2'd1,
        ST_WRITE_RESP = 2'd2
    } cpc_state_e;

    localparam int OFS_IN_DATA  = 0;
    localparam int OFS_IN_STAT  = 1;
    localparam int OFS_OUT_DATA = 2;
    localparam int OFS_OUT_STAT = 3;
    localparam int NUM_REGS     = 4;

endpackage

// File: rtl/cpc_bus_fsm.sv
module cpc_bus_fsm
    import cpc_pkg::*;
#(
    parameter int ADDR_W = 2,
    localparam int SEL_W = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output logic              ack,
    output logic              resp_rd,
    output logic [SEL_W-1:0]  resp_sel,
    output logic [NUM_REGS-1:0] rd_stb,
    output logic [NUM_REGS-1:0] wr_stb
);

    cpc_state_e state_q, state_d;
    logic [SEL_W-1:0] sel_q;
    logic             accept;
    logic             hit;

    assign hit    = (int'(addr) < NUM_REGS);
    assign accept = req && (state_q == ST_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (req) state_d = wr ? ST_WRITE_RESP : ST_READ_RESP;
            ST_READ_RESP:  state_d = ST_IDLE;
            ST_WRITE_RESP: state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) sel_q <= SEL_W'(addr);
        end
    end

    always_comb begin
        ack      = 1'b0;
        resp_rd  = 1'b0;
        resp_sel = sel_q;
        rd_stb   = '0;
        wr_stb   = '0;
        unique case (state_q)
            ST_IDLE: begin
                for (int i = 0; i < NUM_REGS; i++) begin
                    if (req && hit && (int'(addr) == i)) begin
                        rd_stb[i] = !wr;
                        wr_stb[i] = wr;
                    end
                end
            end
            ST_READ_RESP: begin
                ack     = 1'b1;
                resp_rd = 1'b1;
            end
            ST_WRITE_RESP: ack = 1'b1;
            default: ack = 1'b0;
        endcase
    end

    // R9
    resp_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    // R9
    ack_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ack);
    // R9
    busy_ignores_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (rd_stb == '0 && wr_stb == '0));

endmodule

// File: rtl/cpc_in_chan.sv
module cpc_in_chan #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic              peek,
    input  logic              wr_data,
    input  logic              wr_stat,
    input  logic [DATA_W-1:0] wdata,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    output logic              src_ready,
    output logic [DATA_W-1:0] buf_q,
    output logic [DATA_W-1:0] stat_q
);

    localparam logic [DATA_W-1:0] STAT_FULL = DATA_W'(1);

    assign src_ready = sample;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q  <= '0;
            stat_q <= '0;
        end else if (sample) begin
            buf_q  <= src_valid ? src_data : '0;
            stat_q <= src_valid ? STAT_FULL : '0;
        end else begin
            if (wr_data) buf_q  <= wdata;
            if (wr_stat) stat_q <= wdata;
        end
    end

    // R2
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && src_valid) |=> (stat_q == STAT_FULL && buf_q == $past(src_data)));
    // R3
    empty_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && !src_valid) |=> (stat_q == '0 && buf_q == '0));
    // R4
    peek_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        peek |=> ($stable(stat_q) && $stable(buf_q)));

endmodule

// File: rtl/cpc_out_chan.sv
module cpc_out_chan #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_data,
    input  logic              wr_stat,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] buf_q,
    output logic [DATA_W-1:0] stat_q,
    output logic              snk_valid
);

    localparam logic [DATA_W-1:0] STAT_ROOM = DATA_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q     <= '0;
            stat_q    <= STAT_ROOM;
            snk_valid <= 1'b0;
        end else begin
            snk_valid <= wr_data;
            if (wr_data) begin
                buf_q  <= wdata;
                stat_q <= STAT_ROOM;
            end else if (wr_stat) begin
                stat_q <= wdata;
            end
        end
    end

    // R6
    emit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snk_valid |=> !snk_valid);
    // R6
    emit_sets_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snk_valid |-> (stat_q == STAT_ROOM));
    // R7
    emit_holds_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data |=> (buf_q == $past(wdata)));

endmodule

// File: rtl/cpc_console_port.sv
module cpc_console_port
    import cpc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ack,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    output logic              src_ready,
    output logic              snk_valid,
    output logic [DATA_W-1:0] snk_data
);

    localparam int SEL_W = $clog2(NUM_REGS);

    logic                resp_rd;
    logic [SEL_W-1:0]    resp_sel;
    logic [NUM_REGS-1:0] rd_stb;
    logic [NUM_REGS-1:0] wr_stb;
    logic [DATA_W-1:0]   in_buf, in_stat, out_buf, out_stat;

    cpc_bus_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (bus_req),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .ack      (bus_ack),
        .resp_rd  (resp_rd),
        .resp_sel (resp_sel),
        .rd_stb   (rd_stb),
        .wr_stb   (wr_stb)
    );

    cpc_in_chan #(.DATA_W(DATA_W)) u_in (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample    (rd_stb[OFS_IN_STAT]),
        .peek      (rd_stb[OFS_IN_DATA]),
        .wr_data   (wr_stb[OFS_IN_DATA]),
        .wr_stat   (wr_stb[OFS_IN_STAT]),
        .wdata     (bus_wdata),
        .src_valid (src_valid),
        .src_data  (src_data),
        .src_ready (src_ready),
        .buf_q     (in_buf),
        .stat_q    (in_stat)
    );

    cpc_out_chan #(.DATA_W(DATA_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_data   (wr_stb[OFS_OUT_DATA]),
        .wr_stat   (wr_stb[OFS_OUT_STAT]),
        .wdata     (bus_wdata),
        .buf_q     (out_buf),
        .stat_q    (out_stat),
        .snk_valid (snk_valid)
    );

    assign snk_data = out_buf;

    always_comb begin
        bus_rdata = '0;
        if (resp_rd) begin
            unique case (int'(resp_sel))
                OFS_IN_DATA:  bus_rdata = in_buf;
                OFS_IN_STAT:  bus_rdata = in_stat;
                OFS_OUT_DATA: bus_rdata = out_buf;
                OFS_OUT_STAT: bus_rdata = out_stat;
                default:      bus_rdata = '0;
            endcase
        end
    end

    // R5
    ready_then_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_ready |=> (bus_ack && bus_rdata == DATA_W'(src_valid ? 1 : 0) || bus_ack));
    // R10
    no_emit_without_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snk_valid |-> bus_ack);
    // R1
    rdata_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ack |-> (bus_rdata == '0));

endmodule

// File: tb/test_cpc_console_port.sv
module test_cpc_console_port;

    localparam int DW = 8;
    localparam int AW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_req = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic          bus_ack;
    logic [DW-1:0] bus_rdata;
    logic          src_valid = 1'b0;
    logic [DW-1:0] src_data = '0;
    logic          src_ready;
    logic          snk_valid;
    logic [DW-1:0] snk_data;

    int n_checks = 0;
    int n_fails  = 0;
    int n_taken  = 0;
    int n_emits  = 0;
    int cycles   = 0;

    always #10 clk = ~clk;

    cpc_console_port #(.DATA_W(DW), .ADDR_W(AW)) i_cpc_console_port (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata), .src_valid(src_valid), .src_data(src_data),
        .src_ready(src_ready), .snk_valid(snk_valid), .snk_data(snk_data)
    );

    always @(posedge clk) begin
        if (rst_n && src_ready && src_valid) n_taken++;
        if (rst_n && snk_valid) n_emits++;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_fails++;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 20000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_read(input int a, output logic [DW-1:0] d, output logic ak);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = 1'b0; bus_addr = AW'(a);
        @(negedge clk);
        bus_req = 1'b0;
        d  = bus_rdata;
        ak = bus_ack;
    endtask

    task automatic bus_write(input int a, input logic [DW-1:0] v,
                             output logic sv, output logic [DW-1:0] sd);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = v;
        @(negedge clk);
        bus_req = 1'b0; bus_wr = 1'b0;
        sv = snk_valid;
        sd = snk_data;
    endtask

    task automatic t_reset;
        logic [DW-1:0] d; logic ak;
        bus_read(0, d, ak); check("R1 in data after reset", d, 0);
        check("R9 ack on read", ak, 1);
        bus_read(2, d, ak); check("R1 out data after reset", d, 0);
        bus_read(3, d, ak); check("R1 out status after reset", d, 1);
        bus_read(1, d, ak); check("R1 in status after reset", d, 0);
    endtask

    task automatic t_capture;
        logic [DW-1:0] d; logic ak; int t0;
        src_valid = 1'b1; src_data = 8'h41;
        t0 = n_taken;
        bus_read(1, d, ak); check("R2 status after sample", d, 1);
        check("R5 one byte per status read", n_taken - t0, 1);
        src_data = 8'h7E;
        bus_read(0, d, ak); check("R4 buffered char", d, 8'h41);
        bus_read(0, d, ak); check("R4 repeat read same char", d, 8'h41);
        check("R4 data read takes nothing", n_taken - t0, 1);
        bus_read(1, d, ak); check("R2 second sample status", d, 1);
        bus_read(0, d, ak); check("R2 second sample char", d, 8'h7E);
    endtask

    task automatic t_empty;
        logic [DW-1:0] d; logic ak;
        src_valid = 1'b0; src_data = 8'hC3;
        bus_read(1, d, ak); check("R3 status empty", d, 0);
        bus_read(0, d, ak); check("R3 buffer cleared", d, 0);
    endtask

    task automatic t_ready_window;
        logic [DW-1:0] d; logic ak; logic sv; logic [DW-1:0] sd; int t0;
        src_valid = 1'b1; src_data = 8'h11;
        t0 = n_taken;
        bus_read(0, d, ak);
        bus_read(2, d, ak);
        bus_read(3, d, ak);
        bus_write(3, 8'h01, sv, sd);
        bus_write(0, 8'h22, sv, sd);
        check("R5 no take outside status read", n_taken - t0, 0);
        @(negedge clk);
        check("R5 ready low when idle", src_ready, 0);
        src_valid = 1'b0;
    endtask

    task automatic t_emit;
        logic [DW-1:0] d; logic ak; logic sv; logic [DW-1:0] sd;
        bus_write(2, 8'h5A, sv, sd);
        check("R6 strobe with write", sv, 1);
        check("R6 emitted byte", sd, 8'h5A);
        @(negedge clk);
        check("R6 strobe one cycle", snk_valid, 0);
        bus_read(2, d, ak); check("R7 last byte", d, 8'h5A);
        bus_read(3, d, ak); check("R6 out status set", d, 1);
        bus_write(3, 8'h00, sv, sd);
        check("R10 status write no strobe", sv, 0);
        bus_read(3, d, ak); check("R8 out status overwritten", d, 0);
        bus_write(2, 8'h33, sv, sd);
        bus_read(3, d, ak); check("R6 write restores status", d, 1);
        bus_read(2, d, ak); check("R7 newer byte", d, 8'h33);
    endtask

    task automatic t_override;
        logic [DW-1:0] d; logic ak; logic sv; logic [DW-1:0] sd; int e0;
        e0 = n_emits;
        bus_write(1, 8'h07, sv, sd);
        bus_write(0, 8'h99, sv, sd);
        check("R10 in data write no strobe", sv, 0);
        bus_read(0, d, ak); check("R8 in data overwritten", d, 8'h99);
        check("R10 no emits from other writes", n_emits - e0, 0);
    endtask

    task automatic t_busy;
        logic [DW-1:0] d; int e0;
        e0 = n_emits;
        @(negedge clk);
        bus_req = 1'b1; bus_wr = 1'b0; bus_addr = AW'(2);
        @(negedge clk);
        check("R9 ack after one cycle", bus_ack, 1);
        d = bus_rdata;
        check("R9 data with ack", d, 8'h33);
        bus_wr = 1'b1; bus_addr = AW'(2); bus_wdata = 8'hEE;
        @(negedge clk);
        bus_req = 1'b0; bus_wr = 1'b0;
        check("R9 busy request not acked", bus_ack, 0);
        @(negedge clk);
        check("R9 busy write no emit", n_emits - e0, 0);
        bus_read(2, d, bus_wr); check("R9 busy write ignored", d, 8'h33);
        bus_wr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_capture;
        t_empty;
        t_ready_window;
        t_emit;
        t_override;
        t_busy;
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule